// File: doc/BRIEF.md
# Intel HEX Record Loader

This block takes a stream of ASCII characters, one per accepted `rx_valid`/`rx_ready` handshake, the way a serial receiver would deliver them. It parses Intel HEX text records and checks each record's checksum. For accepted data records it emits byte writes to a program memory that is organised as 16-bit words.

Each write carries the full 32-bit byte address, the data byte, the word address and a flag that says which half of the word the byte belongs to. Extended address records set an upper address base that is added to later data records. An end-of-file record stops the loader until the next reset.

Payload bytes are held in a small record buffer until the checksum has been confirmed. Only then is the buffer drained to memory. While it drains, the character input is stalled, so memory back-pressure reaches the character source.

Errors are reported as single-cycle pulses, one line for each error class:
- a malformed character or an oversized record,
- a checksum failure,
- a write that falls outside the memory.

Top module: `ihex_loader`

## Requirements
- R1: A record is ':' followed by count (1 byte), load address (2 bytes, high byte first), type (1 byte), count data bytes, then checksum (1 byte), each byte given as two hex digits with the high nibble first. A type 0x00 record of N bytes writes byte i, for i = 0..N-1 in order, to base + load + i.
- R2: Hex digits 0-9, A-F and a-f are all accepted, and upper and lower case give the same byte value.
- R3: A record is valid only if the 8-bit sum of count, address, type, data and checksum bytes is zero. A failing record produces no writes and no base change, and pulses `err_sum` for exactly one cycle.
- R4: Any character other than a hex digit, appearing after ':' and before the record's last checksum digit, pulses `err_fmt` for one cycle and discards the record. Between records, every character other than ':' is ignored, CR (0x0D) and LF (0x0A) included.
- R5: A count larger than BUF_DEPTH (default 32) pulses `err_fmt` as soon as the count byte completes and discards the record.
- R6: For each write, `wr_word` equals the byte address shifted right by one, and `wr_hi` equals bit 0 of the byte address. For example, byte 0x7FFF maps to word 0x3FFF with `wr_hi` = 1.
- R7: A byte whose address is MEM_BYTES (default 32768) or above is not written and pulses `err_range` once. The in-range bytes of the same record are still written.
- R8: A valid type 0x02 record with count 2 sets the base to its 16-bit payload shifted left by 4. A valid type 0x04 record with count 2 sets the base to its payload shifted left by 16. The latest such record replaces the base, and the base is 0 after reset.
- R9: A valid type 0x01 record raises `done`. From then until reset, `done` stays high, characters are still accepted, and they are ignored.
- R10: Valid records of type 0x03, 0x05, or any type not named above, cause no write, no error and no base change.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_byte` hold steady. `rx_ready` is low whenever a write is pending.
- R12: After reset, `done`, `wr_valid` and all error pulses are low, and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Character available |
| rx_data | input | 8 | ASCII character |
| rx_ready | output | 1 | Loader accepts a character this cycle |
| wr_valid | output | 1 | Byte write pending |
| wr_ready | input | 1 | Memory takes the pending write |
| wr_addr | output | 32 | Byte address of the write |
| wr_byte | output | 8 | Data byte |
| wr_word | output | $clog2(MEM_BYTES)-1 | 16-bit word address (byte address >> 1) |
| wr_hi | output | 1 | 1 = high byte of the word |
| err_fmt | output | 1 | Bad character or oversized count (pulse) |
| err_sum | output | 1 | Checksum failure (pulse) |
| err_range | output | 1 | Write beyond memory dropped (pulse) |
| done | output | 1 | End-of-file record seen |

## Verification
The assertions watch four properties on every cycle:
- the write handshake stays stable under back-pressure and input stalls while a write is pending;
- no write leaves the memory range;
- the word and half mapping matches the byte address;
- `done` is sticky and suppresses writes, and a checksum failure is never followed by a write.

Whether the right bytes reach the right addresses can only be shown by the bench's scenarios. The same holds for:
- both digit cases decoding to the same byte;
- rejected records leaving memory and base untouched;
- extended segment and linear bases combining with load addresses;
- partial out-of-range records.

The bench's scoreboard predicts every write from the record contents it sends.

// File: rtl/ihex_pkg.sv
package ihex_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_COUNT,
      ST_ADDR_H,
      ST_ADDR_L,
      ST_TYPE,
      ST_DATA,
      ST_SUM,
      ST_DRAIN,
      ST_DONE
   } ld_state_t;

   localparam logic [7:0] REC_DATA = 8'h00;
   localparam logic [7:0] REC_EOF  = 8'h01;
   localparam logic [7:0] REC_SEG  = 8'h02;
   localparam logic [7:0] REC_LIN  = 8'h04;

   localparam logic [7:0] CH_COLON = 8'h3A;

endpackage

// File: rtl/ihex_hexdig.sv
module ihex_hexdig (
   input  logic [7:0] ch,
   output logic [3:0] nib,
   output logic       is_hex
);

   always_comb begin
      is_hex = 1'b1;
      nib    = 4'h0;
      if (ch >= 8'h30 && ch <= 8'h39) begin
         nib = ch[3:0];
      end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
         nib = ch[3:0] + 4'd9;
      end else begin
         is_hex = 1'b0;
      end
   end

endmodule

// File: rtl/ihex_rec_buf.sv
module ihex_rec_buf #(
   parameter int DEPTH = 32,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [IW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/ihex_addr_gen.sv
module ihex_addr_gen #(
   parameter int unsigned MEM_BYTES = 32768,
   localparam int MEM_AW = $clog2(MEM_BYTES)
) (
   input  logic [31:0]       base,
   input  logic [15:0]       load,
   input  logic [7:0]        idx,
   output logic [31:0]       addr,
   output logic              in_range,
   output logic [MEM_AW-2:0] word,
   output logic              hi
);

   localparam bit POW2 = ((MEM_BYTES & (MEM_BYTES - 1)) == 0);

   assign addr = base + {16'h0000, load} + {24'h000000, idx};
   assign word = addr[MEM_AW-1:1];
   assign hi   = addr[0];

   generate
      if (POW2) begin : g_pow2
         assign in_range = (addr[31:MEM_AW] == '0);
      end else begin : g_cmp
         assign in_range = (addr < 32'(MEM_BYTES));
      end
   endgenerate

endmodule

// File: rtl/ihex_loader.sv
module ihex_loader #(
   parameter int unsigned MEM_BYTES = 32768,
   parameter int          BUF_DEPTH = 32,
   localparam int MEM_AW = $clog2(MEM_BYTES),
   localparam int BIW    = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [31:0]       wr_addr,
   output logic [7:0]        wr_byte,
   output logic [MEM_AW-2:0] wr_word,
   output logic              wr_hi,
   output logic              err_fmt,
   output logic              err_sum,
   output logic              err_range,
   output logic              done
);
   import ihex_pkg::*;

   generate
      if (BUF_DEPTH < 2 || BUF_DEPTH > 256) begin : g_bad_depth
         $error("BUF_DEPTH must lie in 2..256");
      end
      if (MEM_BYTES < 4 || MEM_BYTES > 32'h4000_0000 || MEM_BYTES[0]) begin : g_bad_mem
         $error("MEM_BYTES must be even and in 4..2^30");
      end
   endgenerate

   ld_state_t   state;
   logic [3:0]  nib_hi;
   logic        nib_phase;
   logic [7:0]  sum;
   logic [7:0]  cnt;
   logic [15:0] load;
   logic [7:0]  rtype;
   logic [7:0]  idx;
   logic [31:0] base;
   logic [7:0]  pl0, pl1;

   logic [3:0]  nib;
   logic        is_hex;
   logic        acc, in_rec, byte_done, buf_we, in_range, advance;
   logic [7:0]  full_byte, idx_nx, sum_nx;

   ihex_hexdig u_dig (
      .ch     (rx_data),
      .nib    (nib),
      .is_hex (is_hex)
   );

   ihex_rec_buf #(.DEPTH(BUF_DEPTH)) u_buf (
      .clk   (clk),
      .we    (buf_we),
      .waddr (idx[BIW-1:0]),
      .wdata (full_byte),
      .raddr (idx[BIW-1:0]),
      .rdata (wr_byte)
   );

   ihex_addr_gen #(.MEM_BYTES(MEM_BYTES)) u_agen (
      .base     (base),
      .load     (load),
      .idx      (idx),
      .addr     (wr_addr),
      .in_range (in_range),
      .word     (wr_word),
      .hi       (wr_hi)
   );

   assign rx_ready  = (state != ST_DRAIN);
   assign acc       = rx_valid && rx_ready;
   assign in_rec    = (state == ST_COUNT) || (state == ST_ADDR_H) || (state == ST_ADDR_L) ||
                      (state == ST_TYPE)  || (state == ST_DATA)   || (state == ST_SUM);
   assign full_byte = {nib_hi, nib};
   assign byte_done = acc && in_rec && is_hex && nib_phase;
   assign buf_we    = byte_done && (state == ST_DATA);
   assign idx_nx    = idx + 8'd1;
   assign sum_nx    = sum + full_byte;
   assign wr_valid  = (state == ST_DRAIN) && in_range;
   assign advance   = (state == ST_DRAIN) && (!in_range || wr_ready);
   assign done      = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         nib_hi    <= 4'h0;
         nib_phase <= 1'b0;
         sum       <= 8'h00;
         cnt       <= 8'h00;
         load      <= 16'h0000;
         rtype     <= 8'h00;
         idx       <= 8'h00;
         base      <= 32'h0;
         pl0       <= 8'h00;
         pl1       <= 8'h00;
         err_fmt   <= 1'b0;
         err_sum   <= 1'b0;
         err_range <= 1'b0;
      end else begin
         err_fmt   <= 1'b0;
         err_sum   <= 1'b0;
         err_range <= 1'b0;
         if (state == ST_IDLE) begin
            if (acc && rx_data == CH_COLON) begin
               state     <= ST_COUNT;
               sum       <= 8'h00;
               nib_phase <= 1'b0;
            end
         end else if (in_rec) begin
            if (acc && !is_hex) begin
               err_fmt <= 1'b1;
               state   <= ST_IDLE;
            end else if (acc && !nib_phase) begin
               nib_hi    <= nib;
               nib_phase <= 1'b1;
            end else if (byte_done) begin
               nib_phase <= 1'b0;
               sum       <= sum_nx;
               case (state)
                  ST_COUNT: begin
                     cnt <= full_byte;
                     if (int'(full_byte) > BUF_DEPTH) begin
                        err_fmt <= 1'b1;
                        state   <= ST_IDLE;
                     end else begin
                        state <= ST_ADDR_H;
                     end
                  end
                  ST_ADDR_H: begin
                     load[15:8] <= full_byte;
                     state      <= ST_ADDR_L;
                  end
                  ST_ADDR_L: begin
                     load[7:0] <= full_byte;
                     state     <= ST_TYPE;
                  end
                  ST_TYPE: begin
                     rtype <= full_byte;
                     idx   <= 8'h00;
                     state <= (cnt == 8'h00) ? ST_SUM : ST_DATA;
                  end
                  ST_DATA: begin
                     if (idx == 8'h00) pl0 <= full_byte;
                     if (idx == 8'h01) pl1 <= full_byte;
                     idx <= idx_nx;
                     if (idx_nx == cnt) state <= ST_SUM;
                  end
                  default: begin
                     if (sum_nx != 8'h00) begin
                        err_sum <= 1'b1;
                        state   <= ST_IDLE;
                     end else begin
                        state <= ST_IDLE;
                        case (rtype)
                           REC_DATA: begin
                              idx <= 8'h00;
                              if (cnt != 8'h00) state <= ST_DRAIN;
                           end
                           REC_EOF: state <= ST_DONE;
                           REC_SEG: if (cnt == 8'd2) base <= {12'h000, pl0, pl1, 4'h0};
                           REC_LIN: if (cnt == 8'd2) base <= {pl0, pl1, 16'h0000};
                           default: ;
                        endcase
                     end
                  end
               endcase
            end
         end else if (state == ST_DRAIN) begin
            if (advance) begin
               if (!in_range) err_range <= 1'b1;
               idx <= idx_nx;
               if (idx_nx == cnt) state <= ST_IDLE;
            end
         end
      end
   end

endmodule

// File: rtl/ihex_loader_chk.sv
module ihex_loader_chk #(
   parameter int unsigned MEM_BYTES = 32768,
   localparam int MEM_AW = $clog2(MEM_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_ready,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [31:0]       wr_addr,
   input logic [7:0]        wr_byte,
   input logic [MEM_AW-2:0] wr_word,
   input logic              wr_hi,
   input logic              err_sum,
   input logic              done
);

   // R11
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_byte));

   // R11
   input_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !rx_ready);

   // R7
   write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_addr < 32'(MEM_BYTES)));

   // R6
   word_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ({wr_word, wr_hi} == wr_addr[MEM_AW-1:0]));

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_valid && rx_ready);

   // R3
   sum_fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_sum |-> !wr_valid);

endmodule

bind ihex_loader ihex_loader_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_ready (rx_ready),
   .wr_valid (wr_valid),
   .wr_ready (wr_ready),
   .wr_addr  (wr_addr),
   .wr_byte  (wr_byte),
   .wr_word  (wr_word),
   .wr_hi    (wr_hi),
   .err_sum  (err_sum),
   .done     (done)
);

// File: tb/test_ihex_loader.sv
`timescale 1ns/1ps
module test_ihex_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_ready;
   logic        wr_valid;
   logic        wr_ready = 1'b1;
   logic [31:0] wr_addr;
   logic [7:0]  wr_byte;
   logic [13:0] wr_word;
   logic        wr_hi;
   logic        err_fmt, err_sum, err_range, done;

   always #2.5 clk = ~clk;

   ihex_loader i_ihex_loader (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte),
      .wr_word(wr_word), .wr_hi(wr_hi), .err_fmt(err_fmt), .err_sum(err_sum),
      .err_range(err_range), .done(done)
   );

   typedef struct { logic [31:0] a; logic [7:0] d; } wr_t;
   wr_t exp_q[$];

   int total = 0, bad = 0;
   int n_fmt = 0, n_sum = 0, n_range = 0;
   int e_fmt = 0, e_sum = 0, e_range = 0;
   logic [31:0] m_base = 32'h0;
   bit   m_done = 1'b0;
   bit   bp_on = 1'b0;
   int   cyc = 0;
   logic [7:0] pay [0:255];

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // back-pressure pattern
   always @(posedge clk) begin
      #1;
      cyc++;
      wr_ready = !bp_on || (cyc % 3 != 0);
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (err_fmt)   n_fmt++;
         if (err_sum)   n_sum++;
         if (err_range) n_range++;
         if (wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1 unexpected write", wr_addr, 32'hFFFF_FFFF);
            end else begin
               wr_t e;
               e = exp_q.pop_front();
               check(wr_addr == e.a, "R1 write address", wr_addr, e.a);
               check(wr_byte == e.d, "R1 write data", {24'h0, wr_byte}, {24'h0, e.d});
               check({wr_word, wr_hi} == e.a[14:0], "R6 word/half map", {17'h0, wr_word, wr_hi}, {17'h0, e.a[14:0]});
            end
         end
      end
   end

   function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
      if (n < 4'd10) return 8'h30 + {4'h0, n};
      return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
   endfunction

   task automatic put_char(input logic [7:0] c);
      @(negedge clk);
      rx_data  = c;
      rx_valid = 1'b1;
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
      #1;
      rx_valid = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] b, input bit lower);
      put_char(hexc(b[7:4], lower));
      put_char(hexc(b[3:0], lower));
   endtask

   task automatic settle();
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic send_rec(input logic [7:0] ty, input logic [15:0] la, input int n,
                           input bit bad_sum, input bit lower);
      logic [7:0] s, chk;
      s = 8'(n) + la[15:8] + la[7:0] + ty;
      for (int i = 0; i < n; i++) s = s + pay[i];
      chk = 8'h00 - s;
      if (bad_sum) chk = chk ^ 8'h01;
      if (!m_done) begin
         if (bad_sum) e_sum++;
         else begin
            case (ty)
               8'h00: for (int i = 0; i < n; i++) begin
                  logic [31:0] a;
                  a = m_base + {16'h0, la} + 32'(i);
                  if (a < 32'd32768) exp_q.push_back('{a, pay[i]});
                  else e_range++;
               end
               8'h01: m_done = 1'b1;
               8'h02: if (n == 2) m_base = {12'h0, pay[0], pay[1], 4'h0};
               8'h04: if (n == 2) m_base = {pay[0], pay[1], 16'h0};
               default: ;
            endcase
         end
      end
      put_char(8'h3A);
      put_byte(8'(n), lower);
      put_byte(la[15:8], lower);
      put_byte(la[7:0], lower);
      put_byte(ty, lower);
      for (int i = 0; i < n; i++) put_byte(pay[i], lower);
      put_byte(chk, lower);
      settle();
   endtask

   task automatic expect_clean(input string tag);
      check(exp_q.size() == 0, {tag, " pending writes"}, 32'(exp_q.size()), 0);
      check(n_fmt == e_fmt, {tag, " err_fmt count"}, 32'(n_fmt), 32'(e_fmt));
      check(n_sum == e_sum, {tag, " err_sum count"}, 32'(n_sum), 32'(e_sum));
      check(n_range == e_range, {tag, " err_range count"}, 32'(n_range), 32'(e_range));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check(done == 1'b0, "R12 done", {31'h0, done}, 0);
      check(wr_valid == 1'b0, "R12 wr_valid", {31'h0, wr_valid}, 0);
      check(rx_ready == 1'b1, "R12 rx_ready", {31'h0, rx_ready}, 1);
      check({err_fmt, err_sum, err_range} == 3'b000, "R12 error pulses", {29'h0, err_fmt, err_sum, err_range}, 0);

      // R1 R11: 16-byte data record at 0x7000 under back-pressure
      bp_on = 1'b1;
      for (int i = 0; i < 16; i++) pay[i] = 8'(8'h3C + i * 7);
      send_rec(8'h00, 16'h7000, 16, 1'b0, 1'b0);
      expect_clean("R1 R11 data record");
      bp_on = 1'b0;

      // R4: CR/LF between records ignored; R2 lower-case digits
      put_char(8'h0D); put_char(8'h0A);
      for (int i = 0; i < 5; i++) pay[i] = 8'(8'hAB + i * 17);
      send_rec(8'h00, 16'h0123, 5, 1'b0, 1'b1);
      expect_clean("R2 lower case");

      // R3: bad checksum discards
      for (int i = 0; i < 4; i++) pay[i] = 8'hE0 + 8'(i);
      send_rec(8'h00, 16'h0200, 4, 1'b1, 1'b0);
      expect_clean("R3 bad checksum");

      // R4: non-hex character inside a record
      put_char(8'h3A); put_byte(8'h02, 1'b0); put_byte(8'h00, 1'b0);
      put_byte(8'h10, 1'b0); put_byte(8'h00, 1'b0);
      put_char(8'h34); put_char(8'h47);
      e_fmt++;
      settle();
      expect_clean("R4 bad character");

      // R5: oversized count (0x40 > 32)
      put_char(8'h3A); put_byte(8'h40, 1'b0); put_byte(8'h00, 1'b0); put_byte(8'h00, 1'b0);
      e_fmt++;
      settle();
      expect_clean("R5 oversized count");

      // R8: segment base 0x0100 -> 0x1000
      pay[0] = 8'h01; pay[1] = 8'h00;
      send_rec(8'h02, 16'h0000, 2, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) pay[i] = 8'h51 + 8'(i);
      send_rec(8'h00, 16'h0010, 3, 1'b0, 1'b0);
      expect_clean("R8 segment base");

      // R8 R7: linear base 0x0001 -> 0x10000, all out of range
      pay[0] = 8'h00; pay[1] = 8'h01;
      send_rec(8'h04, 16'h0000, 2, 1'b0, 1'b0);
      pay[0] = 8'h11; pay[1] = 8'h22;
      send_rec(8'h00, 16'h0000, 2, 1'b0, 1'b0);
      expect_clean("R8 R7 linear base");
      pay[0] = 8'h00; pay[1] = 8'h00;
      send_rec(8'h04, 16'h0000, 2, 1'b0, 1'b0);

      // R7 R6: boundary record at 0x7FFE, 4 bytes
      for (int i = 0; i < 4; i++) pay[i] = 8'hC0 + 8'(i);
      send_rec(8'h00, 16'h7FFE, 4, 1'b0, 1'b0);
      expect_clean("R7 boundary");

      // R10: start address records ignored
      for (int i = 0; i < 4; i++) pay[i] = 8'h12 * 8'(i + 1);
      send_rec(8'h03, 16'h0000, 4, 1'b0, 1'b0);
      send_rec(8'h05, 16'h0000, 4, 1'b0, 1'b0);
      send_rec(8'h00, 16'h0040, 0, 1'b0, 1'b0);
      pay[0] = 8'hAA;
      send_rec(8'h00, 16'h0040, 1, 1'b0, 1'b0);
      expect_clean("R10 ignored types");

      // R9: end of file
      send_rec(8'h01, 16'h0000, 0, 1'b0, 1'b0);
      check(done == 1'b1, "R9 done after EOF", {31'h0, done}, 1);
      for (int i = 0; i < 3; i++) pay[i] = 8'h77;
      send_rec(8'h00, 16'h0000, 3, 1'b0, 1'b0);
      send_rec(8'h00, 16'h0000, 3, 1'b1, 1'b0);
      check(done == 1'b1, "R9 done sticky", {31'h0, done}, 1);
      check(rx_ready == 1'b1, "R9 input still accepted", {31'h0, rx_ready}, 1);
      expect_clean("R9 input ignored");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule